// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block turns a source clock into a slower clock whose ratio N is chosen at run time, any integer from 2 up to the counter limit. It has two duty modes. In the half-duty mode the output is high for exactly half of each divided period, for even and for odd N alike. In the ratio mode the output is high for a chosen number of whole source cycles. Each divided period starts with its low phase.

A rising-edge counter runs from 0 to N−1 and flips a phase register at two compare points. The first compare point is N−1−H, where H is the high time in source cycles. The second is N−1, and at that point the counter also wraps. For odd N in the half-duty mode, a falling-edge register makes a copy of that phase that lags by half a source cycle. The output is the AND of the two phases, so the high time becomes N/2 source cycles. Ratio, duty mode and high time are taken at period boundaries only, so a period that has already started always finishes with its own settings.

Top module: `clkdiv_prog`

## Requirements
- R1: While rst_n is low, clk_out is 0. After release, the first period starts low: for N=6 in half-duty mode, clk_out stays low after the first two rising edges and goes high after the third.
- R2: In half-duty mode with even N, clk_out is high for N/2 and low for N/2 source cycles.
- R3: In half-duty mode with odd N, clk_out is high for N half source periods and low for N half source periods. The high time starts on a falling edge of clk and ends on a rising edge.
- R4: In ratio mode (duty50_en=0), clk_out is high for high_cnt source cycles and low for N−high_cnt. The rise comes at the rising edge after counter value N−1−high_cnt and the fall comes at the edge after value N−1. For example, N=7 with high_cnt=4 gives 3 cycles low and 4 high, and N=3 with high_cnt=1 gives 2 low and 1 high.
- R5: With N=2, clk_out changes on every rising edge of clk in both modes.
- R6: In ratio mode, a high_cnt of 0 acts as 1 and a high_cnt of N or more acts as N−1.
- R7: A div_n value of 0 or 1 acts as 2.
- R8: div_n, high_cnt and duty50_en are taken only at the rising edge that ends a period, and at the first rising edge after reset. A change made during a period does not alter the remaining part of that period.
- R9: Every divided period lasts exactly N source cycles, and clk_out is low during the first source cycle of every period.
- R10: The counter width W is a parameter with a default of 8, so N can be as large as 2^W−1 (255). At that ratio R3 still holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_n | input | W | Division ratio N; values below 2 act as 2 |
| high_cnt | input | W | High time in source cycles for ratio mode |
| duty50_en | input | 1 | 1 selects half-duty mode, 0 selects ratio mode |
| clk_out | output | 1 | Divided clock |

## Verification
The bench measures each high run and each low run of clk_out in half source periods. It targets the places where a divider commonly goes wrong. For odd ratios, a design missing the falling-edge stage would give a high time one half period too long. A design with an off-by-one compare point would give periods of N±1 cycles, or a duty cycle that is off by one cycle. A design that does not clamp would stick high or low for settings of 0, for out-of-range high times, and for ratios below 2. It also checks a ratio change made in the middle of a high phase: a design that samples settings every cycle would cut that high phase short. Finally it covers the N=2 extreme, the largest odd ratio, and the low start after reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // smallest ratio the block will run at
  localparam int MIN_DIV = 2;

  typedef enum logic [1:0] {
    MODE_EVEN_HALF = 2'd0,
    MODE_ODD_HALF  = 2'd1,
    MODE_RATIO     = 2'd2
  } div_mode_e;
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] div_n,
  input  logic [W-1:0] high_cnt,
  input  logic         duty50_en,
  output logic [W-1:0] last,
  output logic [W-1:0] flip,
  output div_mode_e    mode,
  output logic         primed
);
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MIN_N = W'(MIN_DIV);

  logic [W-1:0] n_eff, h_eff, last_d, flip_d;
  logic [W:0]   n_plus;
  div_mode_e    mode_d;

  logic [W-1:0] last_q, flip_q;
  div_mode_e    mode_q;

  // decode the requested setting into compare points
  always_comb begin
    n_eff  = (div_n < MIN_N) ? MIN_N : div_n;
    n_plus = {1'b0, n_eff} + {{W{1'b0}}, 1'b1};
    if (duty50_en)
      h_eff = n_plus[W:1];
    else if (high_cnt == '0)
      h_eff = ONE;
    else if (high_cnt >= n_eff)
      h_eff = n_eff - ONE;
    else
      h_eff = high_cnt;
    last_d = n_eff - ONE;
    flip_d = last_d - h_eff;
    if (!duty50_en)
      mode_d = MODE_RATIO;
    else if (n_eff[0])
      mode_d = MODE_ODD_HALF;
    else
      mode_d = MODE_EVEN_HALF;
  end

  // hold the setting for a whole period; load at wrap or first edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= ONE;
      flip_q <= '0;
      mode_q <= MODE_EVEN_HALF;
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (wrap || !primed) begin
        last_q <= last_d;
        flip_q <= flip_d;
        mode_q <= mode_d;
      end
    end
  end

  // before the first edge the decoded request is used directly
  assign last = primed ? last_q : last_d;
  assign flip = primed ? flip_q : flip_d;
  assign mode = primed ? mode_q : mode_d;
endmodule

// File: rtl/clkdiv_rise.sv
module clkdiv_rise #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] last,
  input  logic [W-1:0] flip,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         phase
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic hit_flip;

  assign wrap     = (cnt == last);
  assign hit_flip = (cnt == flip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + ONE;
      if (hit_flip || wrap)
        phase <= ~phase;
    end
  end
endmodule

// File: rtl/clkdiv_fall.sv
module clkdiv_fall
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  div_mode_e mode,
  input  logic      rise_ph,
  output logic      phase
);
  // half-cycle retimed copy in odd half-duty mode, transparent 1 otherwise
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= 1'b0;
    else
      phase <= (mode == MODE_ODD_HALF) ? rise_ph : 1'b1;
  end
endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_n,
  input  logic [W-1:0] high_cnt,
  input  logic         duty50_en,
  output logic         clk_out
);
  logic [W-1:0] last, flip, cnt;
  div_mode_e    mode;
  logic         primed, wrap, rise_ph, fall_ph;

  clkdiv_cfg #(.W(W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (wrap),
    .div_n     (div_n),
    .high_cnt  (high_cnt),
    .duty50_en (duty50_en),
    .last      (last),
    .flip      (flip),
    .mode      (mode),
    .primed    (primed)
  );

  clkdiv_rise #(.W(W)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .last  (last),
    .flip  (flip),
    .cnt   (cnt),
    .wrap  (wrap),
    .phase (rise_ph)
  );

  clkdiv_fall u_fall (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .rise_ph (rise_ph),
    .phase   (fall_ph)
  );

  assign clk_out = rise_ph & fall_ph;
endmodule

// File: rtl/clkdiv_prog_chk.sv
module clkdiv_prog_chk
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] last,
  input logic [W-1:0] flip,
  input div_mode_e    mode,
  input logic         primed,
  input logic         rise_ph,
  input logic         fall_ph,
  input logic         clk_out
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      age <= 2'd0;
    else if (age != 2'd2)
      age <= age + 2'd1;
  end

  // R1: output held low in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_low_in_reset: assert (clk_out == 1'b0)
        else $error("R1 clk_out high during reset");
    end
  end

  // R10: counter never passes the terminal value
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (cnt <= last));

  // R9: terminal count is followed by a fresh period
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && cnt == last) |=> (cnt == '0));

  // R9: first cycle of each period is low
  a_r9_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && cnt == '0) |-> !clk_out);

  // R6: the rise compare point stays below the terminal point
  a_r6_flip_below_last: assert property (@(posedge clk) disable iff (!rst_n)
    flip < last);

  // R3: falling stage follows the rising phase in odd half-duty mode
  a_r3_fall_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && mode == MODE_ODD_HALF) |-> (fall_ph == rise_ph));

  // R2: falling stage is transparent outside odd half-duty mode
  a_r2_fall_open: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && mode != MODE_ODD_HALF) |-> fall_ph);
endmodule

bind clkdiv_prog clkdiv_prog_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cnt),
  .last    (last),
  .flip    (flip),
  .mode    (mode),
  .primed  (primed),
  .rise_ph (rise_ph),
  .fall_ph (fall_ph),
  .clk_out (clk_out)
);

// File: tb/clkdiv_prog_test.sv
module clkdiv_prog_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] div_n;
  logic [W-1:0] high_cnt;
  logic         duty50_en;
  logic         clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // run tracking in half source periods
  int   run_len = 0;
  logic prev    = 1'b0;
  int   hi_w    = 0;
  int   lo_w    = 0;
  int   rises   = 0;
  int   falls   = 0;

  always #10 clk = ~clk;  // 50 MHz

  clkdiv_prog #(.W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_n     (div_n),
    .high_cnt  (high_cnt),
    .duty50_en (duty50_en),
    .clk_out   (clk_out)
  );

  task automatic take_sample();
    if (clk_out === prev) begin
      run_len++;
    end else begin
      if (prev) begin hi_w = run_len; falls++; end
      else      begin lo_w = run_len; rises++; end
      run_len = 1;
      prev = clk_out;
    end
  endtask

  always begin
    @(posedge clk); #5; take_sample();
    @(negedge clk); #5; take_sample();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int n, input int h, input bit d50);
    div_n     = W'(n);
    high_cnt  = W'(h);
    duty50_en = d50;
    begin
      int r0 = rises;
      wait (rises >= r0 + 3);
    end
  endtask

  task automatic measure(input string req, input int exp_hi, input int exp_lo);
    int r0 = rises;
    wait (rises > r0);
    check(hi_w == exp_hi, req, "high half-periods", hi_w, exp_hi);
    check(lo_w == exp_lo, req, "low half-periods", lo_w, exp_lo);
    check(hi_w + lo_w == exp_hi + exp_lo, "R9", "period half-periods",
          hi_w + lo_w, exp_hi + exp_lo);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; div_n = 8'd6; high_cnt = '0; duty50_en = 1'b1;
    repeat (3) @(posedge clk);
    #5 check(clk_out == 1'b0, "R1", "in reset", int'(clk_out), 0);
    @(negedge clk); #5 rst_n = 1'b1;
    @(posedge clk); #5 check(clk_out == 1'b0, "R1", "after edge 1", int'(clk_out), 0);
    @(posedge clk); #5 check(clk_out == 1'b0, "R1", "after edge 2", int'(clk_out), 0);
    @(posedge clk); #5 check(clk_out == 1'b1, "R1", "after edge 3", int'(clk_out), 1);
  endtask

  task automatic test_reset_midrun();
    apply(4, 0, 1'b0);
    @(posedge clk); #3 rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk); #5 check(clk_out == 1'b0, "R1", "held in reset", int'(clk_out), 0);
    end
    @(negedge clk); #5 rst_n = 1'b1;
  endtask

  task automatic test_even();
    apply(4, 0, 1'b1);  measure("R2", 4, 4);
    apply(6, 0, 1'b1);  measure("R2", 6, 6);
    apply(10, 0, 1'b1); measure("R2", 10, 10);
  endtask

  task automatic test_odd();
    apply(3, 0, 1'b1);  measure("R3", 3, 3);
    apply(7, 0, 1'b1);  measure("R3", 7, 7);
    apply(9, 3, 1'b1);  measure("R3", 9, 9);
  endtask

  task automatic test_ratio();
    apply(7, 4, 1'b0); measure("R4", 8, 6);
    apply(3, 1, 1'b0); measure("R4", 2, 4);
    apply(8, 3, 1'b0); measure("R4", 6, 10);
  endtask

  task automatic test_div2();
    apply(2, 0, 1'b1); measure("R5", 2, 2);
    apply(2, 1, 1'b0); measure("R5", 2, 2);
  endtask

  task automatic test_clamp_high();
    apply(5, 0, 1'b0); measure("R6", 2, 8);
    apply(5, 9, 1'b0); measure("R6", 8, 2);
  endtask

  task automatic test_clamp_div();
    apply(0, 0, 1'b1); measure("R7", 2, 2);
    apply(1, 0, 1'b0); measure("R7", 2, 2);
  endtask

  task automatic test_midperiod_change();
    int r0, f0;
    apply(8, 0, 1'b1);
    r0 = rises;
    wait (rises > r0);
    div_n = 8'd4;           // mid high phase of an N=8 period
    f0 = falls;
    wait (falls > f0);
    check(hi_w == 8, "R8", "high of running period", hi_w, 8);
    r0 = rises;
    wait (rises > r0);
    check(lo_w == 4, "R8", "low of next period", lo_w, 4);
    f0 = falls;
    wait (falls > f0);
    check(hi_w == 4, "R8", "high of next period", hi_w, 4);
  endtask

  task automatic test_max_ratio();
    apply(255, 0, 1'b1); measure("R10", 255, 255);
  endtask

  initial begin
    test_reset();
    test_even();
    test_odd();
    test_ratio();
    test_div2();
    test_clamp_high();
    test_clamp_div();
    test_midperiod_change();
    test_reset_midrun();
    test_max_ratio();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule